// File: doc/BRIEF.md
# I2C Channel Select Controller

This block is a small I2C target that owns one 8-bit control byte and uses it to pick which of its downstream bus channels is switched on. SCL and SDA are brought in as plain inputs, cleaned of short spikes, and watched for START and STOP conditions. A transfer addressed to the fixed 7-bit target address is acknowledged. Data bytes from a write are stored, with each new byte replacing the one before. A read shifts the stored byte back out. The block pulls SDA low by raising an output-enable, and a pad outside the block turns that into an open-drain driver.

The enables do not move as soon as the byte lands. A written byte waits until the bus shows a STOP, and only then is it decoded onto the channel enables. The downstream lines are therefore idle when a channel is connected. A repeated START leaves the pending byte waiting. A transfer to any other address is ignored entirely.

Top module: `chsel_i2c_target`

## Requirements
- R1: The target answers only to the 7-bit address 1110000, which is sent MSB first and followed by the R/W bit (1 = read, 0 = write). It acknowledges a matching address by raising `sda_oe` across the ninth SCL pulse.
- R2: A transfer with any other address leaves `sda_oe` low from its address until the following STOP or START, and it leaves both the stored byte and the enables unchanged.
- R3: Every data byte of a write is acknowledged. When several bytes arrive in one write, the stored byte is the last of them.
- R4: The enables follow bits [2:0] of the stored byte. Bit 2 is the enable bit and bits [1:0] are the channel number. 100 selects channel 0 and 101 selects channel 1. A code with bit 2 clear, or with a channel number at or above NUM_CH (11x), selects no channel. Bits [7:3] have no effect.
- R5: At most one bit of `ch_en` is high at any time.
- R6: `ch_en` changes only in reaction to a STOP that follows a write. A repeated START does not apply the pending byte, and until the STOP the previous selection stays in force.
- R7: After reset the stored byte is 0x00, no channel is enabled, `sda_oe` is low and the bus engine is idle.
- R8: A read returns the stored byte MSB first, one bit per SCL pulse. After the master answers with a not-acknowledge, `sda_oe` stays low until the next START.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored. It is not taken as a clock edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the upstream SCL line |
| sda_i | input | 1 | Sensed level of the upstream SDA line |
| sda_oe | output | 1 | High to pull upstream SDA low (open-drain enable) |
| ch_en | output | NUM_CH | One-hot-or-zero downstream channel enables |

## Verification
Two events can fall in the same stretch of bus activity: a byte written to the register, and the moment the applied selection changes. The bench provokes this with writes followed by repeated STARTs and reads, and with multi-byte writes. Every clock it compares `ch_en` with a reference that moves only when the bench itself issues a STOP, so a selection applied early at the write strobe or at a repeated START is caught. Spikes are injected into SCL and SDA in the middle of a byte. The glitched byte is then judged by its acknowledge, by its read-back and by the channel it enables.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK_HOLD,
    ST_WRITE,
    ST_READ,
    ST_READ_ACK,
    ST_READ_NEXT,
    ST_IGNORE
  } bus_state_t;

  localparam int BYTE_W   = 8;
  localparam int ENA_BIT  = 2;
  localparam int CHAN_LSB = 0;
  localparam int CHAN_W   = 2;

endpackage

// File: rtl/chsel_deglitch.sv
module chsel_deglitch #(
  parameter int  FILT_LEN = 8,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic          out_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {2{IDLE_VAL}};
      out_q  <= IDLE_VAL;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == out_q) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        out_q <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign dout = out_q;

  // R9: the filtered level only moves after a full run of differing samples
  assert_filter_run_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_q) |-> ($past(run_q) == CW'(FILT_LEN - 1)));

endmodule

// File: rtl/chsel_bus_engine.sv
module chsel_bus_engine
  import chsel_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1110000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              stop_seen
);
  bus_state_t        state_q;
  logic              scl_d, sda_d;
  logic [BYTE_W-1:0] shift_q;
  logic [2:0]        bit_q;
  logic              is_read_q;
  logic              oe_q;
  logic              start_c, stop_c, rise_c, fall_c;

  assign start_c = scl_d & scl & sda_d & ~sda;
  assign stop_c  = scl_d & scl & ~sda_d & sda;
  assign rise_c  = ~scl_d & scl;
  assign fall_c  = scl_d & ~scl;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      shift_q   <= '0;
      bit_q     <= '0;
      is_read_q <= 1'b0;
      oe_q      <= 1'b0;
      wr_stb    <= 1'b0;
      wr_data   <= '0;
      stop_seen <= 1'b0;
    end else begin
      scl_d     <= scl;
      sda_d     <= sda;
      wr_stb    <= 1'b0;
      stop_seen <= 1'b0;
      if (start_c) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_c) begin
        state_q   <= ST_IDLE;
        oe_q      <= 1'b0;
        stop_seen <= 1'b1;
      end else begin
        unique case (state_q)
          ST_ADDR: if (rise_c) begin
            shift_q <= {shift_q[6:0], sda};
            if (bit_q == 3'd7) begin
              bit_q <= '0;
              if (shift_q[6:0] == DEV_ADDR) begin
                is_read_q <= sda;
                state_q   <= ST_ACK_WAIT;
              end else begin
                state_q <= ST_IGNORE;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
          ST_ACK_WAIT: if (fall_c) begin
            oe_q    <= 1'b1;
            state_q <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (fall_c) begin
            bit_q <= '0;
            if (is_read_q) begin
              shift_q <= rd_data;
              oe_q    <= ~rd_data[BYTE_W-1];
              state_q <= ST_READ;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WRITE;
            end
          end
          ST_WRITE: if (rise_c) begin
            shift_q <= {shift_q[6:0], sda};
            if (bit_q == 3'd7) begin
              bit_q   <= '0;
              wr_stb  <= 1'b1;
              wr_data <= {shift_q[6:0], sda};
              state_q <= ST_ACK_WAIT;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
          ST_READ: if (fall_c) begin
            if (bit_q == 3'd7) begin
              bit_q   <= '0;
              oe_q    <= 1'b0;
              state_q <= ST_READ_ACK;
            end else begin
              shift_q <= {shift_q[6:0], 1'b0};
              oe_q    <= ~shift_q[6];
              bit_q   <= bit_q + 1'b1;
            end
          end
          ST_READ_ACK: if (rise_c) begin
            state_q <= sda ? ST_IGNORE : ST_READ_NEXT;
          end
          ST_READ_NEXT: if (fall_c) begin
            shift_q <= rd_data;
            oe_q    <= ~rd_data[BYTE_W-1];
            bit_q   <= '0;
            state_q <= ST_READ;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = oe_q;

  // R2/R8: a released bus or an ignored transfer never sees SDA pulled low
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !sda_oe);

  // R6: a STOP cannot coincide with storing a byte
  assert_stop_alone_R6: assert property (@(posedge clk) disable iff (rst)
    stop_seen |-> !wr_stb);

endmodule

// File: rtl/chsel_ctrl_reg.sv
module chsel_ctrl_reg
  import chsel_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              stop_seen,
  output logic [BYTE_W-1:0] ctrl_byte,
  output logic [NUM_CH-1:0] ch_en
);
  logic [BYTE_W-1:0] ctrl_q;
  logic              pend_q;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] dec_c;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign dec_c[i] = ctrl_q[ENA_BIT] &&
                      (ctrl_q[CHAN_LSB +: CHAN_W] == CHAN_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      en_q   <= '0;
    end else if (wr_stb) begin
      ctrl_q <= wr_data;
      pend_q <= 1'b1;
    end else if (stop_seen && pend_q) begin
      en_q   <= dec_c;
      pend_q <= 1'b0;
    end
  end

  assign ctrl_byte = ctrl_q;
  assign ch_en     = en_q;

  // R5: never more than one downstream channel on
  assert_onehot_en_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_en));

  // R6: the selection only moves right after a STOP from the bus engine
  assert_commit_on_stop_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(ch_en) |-> $past(stop_seen));

endmodule

// File: rtl/chsel_i2c_target.sv
module chsel_i2c_target
  import chsel_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1110000,
  parameter int         FILT_LEN = 8,
  parameter int         NUM_CH   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NUM_CH-1:0] ch_en
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] raw_c, clean_c;
  logic                 wr_stb, stop_seen;
  logic [BYTE_W-1:0]    wr_data, ctrl_byte;

  assign raw_c = {sda_i, scl_i};

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    chsel_deglitch #(.FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_c[l]),
      .dout(clean_c[l])
    );
  end

  chsel_bus_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .scl      (clean_c[0]),
    .sda      (clean_c[1]),
    .rd_data  (ctrl_byte),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .stop_seen(stop_seen)
  );

  chsel_ctrl_reg #(.NUM_CH(NUM_CH)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .stop_seen(stop_seen),
    .ctrl_byte(ctrl_byte),
    .ch_en    (ch_en)
  );

endmodule

// File: tb/chsel_i2c_target_test.sv
module chsel_i2c_target_test;
  localparam int Q = 30;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NCH-1:0] ch_en;
  logic sda_w;

  int checks = 0, errors = 0, mon_err = 0, cyc = 0;
  bit settle = 1'b1, done = 1'b0;

  logic [7:0] exp_reg = 8'h00;
  logic [NCH-1:0] exp_en = '0;
  logic [7:0] pend_q[$];

  always #2.5 clk = ~clk;
  assign sda_w = sda_m & ~sda_oe;

  chsel_i2c_target uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_w),
    .sda_oe(sda_oe), .ch_en(ch_en)
  );

  function automatic logic [NCH-1:0] decode(input logic [7:0] v);
    logic [NCH-1:0] r = '0;
    if (v[2] && v[1:0] < NCH) r[v[1:0]] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R5/R6 reference comparison every clock outside the STOP window
  always @(negedge clk) begin
    if (!rst && !settle && ch_en !== exp_en) mon_err++;
    if (!rst && $countones(ch_en) > 1) mon_err++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bus_start();
    if (scl == 1'b0) begin
      tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    end
    sda_m = 1'b0; tick(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    settle = 1'b1; sda_m = 1'b1; tick(2 * Q);
    if (pend_q.size() > 0) exp_en = decode(pend_q[$]);
    pend_q.delete();
    settle = 1'b0;
    chk("R6 ch_en matches reference across transfer", mon_err, 0);
  endtask

  // glitch: 1 = SCL spike in a low phase, 2 = SDA spike while SCL high
  task automatic send_byte(input logic [7:0] b, input int glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      if (glitch == 1 && i == 4) begin
        tick(10); scl = 1'b1; tick(3); scl = 1'b0; tick(Q - 13);
      end else tick(Q);
      sda_m = b[i]; tick(Q); scl = 1'b1;
      if (glitch == 2 && i == 2) begin
        tick(10); sda_m = 1'b0; tick(3); sda_m = 1'b1; tick(2 * Q - 13);
      end else tick(2 * Q);
      scl = 1'b0;
    end
    tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = (sda_w == 1'b0); tick(Q); scl = 1'b0;
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
      v = {v[6:0], sda_w}; tick(Q); scl = 1'b0;
    end
    tick(Q); sda_m = nack; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0;
    tick(Q); sda_m = 1'b1;
  endtask

  task automatic write_txn(input logic [7:0] d, input int glitch, input string tag);
    logic a;
    bus_start(); send_byte(8'hE0, 0, a);
    chk({tag, " address ack"}, a, 1);
    send_byte(d, glitch, a);
    chk({tag, " data ack"}, a, 1);
    exp_reg = d; pend_q.push_back(d);
    chk({tag, " enables held before STOP"}, ch_en, exp_en);
    bus_stop();
    chk({tag, " enables after STOP"}, ch_en, decode(d));
  endtask

  task automatic read_txn(input string tag);
    logic a; logic [7:0] v;
    bus_start(); send_byte(8'hE1, 0, a);
    chk({tag, " R1 read address ack"}, a, 1);
    read_byte(1'b1, v);
    chk({tag, " R8 read value"}, v, exp_reg);
    chk({tag, " R8 SDA released after NACK"}, sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    logic a; logic [7:0] v;
    tick(10); rst = 1'b0; tick(5);
    chk("R7 no channel after reset", ch_en, 0);
    chk("R7 SDA released after reset", sda_oe, 0);
    settle = 1'b0;
    read_txn("R7 reset value");

    write_txn(8'h04, 0, "R4 code 100 channel 0");
    write_txn(8'h05, 0, "R4 code 101 channel 1");
    read_txn("R8 readback 05");
    write_txn(8'hFE, 0, "R4 code 11x none");
    write_txn(8'hA5, 0, "R4 upper bits ignored");
    write_txn(8'h03, 0, "R4 bit2 clear none");

    // R3: burst write keeps the last byte
    bus_start(); send_byte(8'hE0, 0, a);
    chk("R3 burst address ack", a, 1);
    send_byte(8'h05, 0, a); chk("R3 burst byte0 ack", a, 1);
    exp_reg = 8'h05; pend_q.push_back(8'h05);
    send_byte(8'h06, 0, a); chk("R3 burst byte1 ack", a, 1);
    exp_reg = 8'h06; pend_q.push_back(8'h06);
    send_byte(8'hF4, 0, a); chk("R3 burst byte2 ack", a, 1);
    exp_reg = 8'hF4; pend_q.push_back(8'hF4);
    bus_stop();
    chk("R3 last burst byte applied", ch_en, 2'b01);

    // R6: repeated START keeps the pending byte waiting
    bus_start(); send_byte(8'hE0, 0, a);
    send_byte(8'h0D, 0, a); chk("R6 data ack before Sr", a, 1);
    exp_reg = 8'h0D; pend_q.push_back(8'h0D);
    bus_start(); send_byte(8'hE1, 0, a);
    chk("R6 ack after repeated start", a, 1);
    read_byte(1'b1, v);
    chk("R8 read after Sr returns new byte", v, 8'h0D);
    chk("R6 old selection held after Sr", ch_en, 2'b01);
    bus_stop();
    chk("R6 committed on true STOP", ch_en, 2'b10);

    // R2: other address ignored
    bus_start(); send_byte(8'h71 << 1, 0, a);
    chk("R2 no ack for other address", a, 0);
    send_byte(8'h04, 0, a);
    chk("R2 no ack for its data", a, 0);
    chk("R2 SDA released", sda_oe, 0);
    bus_stop();
    chk("R2 enables unchanged", ch_en, 2'b10);
    read_txn("R2 register unchanged");

    // R9: spikes
    write_txn(8'h04, 1, "R9 SCL spike ignored");
    read_txn("R9 SCL spike readback");
    write_txn(8'h05, 2, "R9 SDA spike ignored");
    read_txn("R9 SDA spike readback");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule